// File: doc/BRIEF.md
# PAM4 Lane Framer and Precoder

This block builds the transmit frame of a single serial lane and turns it into precoded four-level symbol codes. It takes a stream of payload bits, one per handshake transfer, and four overhead bits. It places each bit into a fixed frame of 88 rows with 64 bit slots per row. The overhead bits open the frame. The last slot of every row is a termination bit, and the block supplies that bit itself.

Adjacent slots are paired into 2-bit symbols, so each row is 32 symbols. Each symbol passes through a 1/(1+D) modulo-4 precoder and leaves the block as a 2-bit Gray code that names one of four line levels. The last symbol of every row is the termination symbol. Its precoder output is forced to one of the two outer levels, which lets a receiver lock to the row structure. Upstream logic delivers payload bits with valid. The block holds ready low during the slots that it fills itself.

Top module: `pam4_lane_framer`

## Requirements
- R1: After reset, sym_valid is 0 and in_ready is 0, because the first slot of the frame is an overhead slot. The precoder state starts at value 0.
- R2: A frame has 88 rows of 64 slots each. In row 0, slots 0 to 3 carry ovh_bits[3], ovh_bits[2], ovh_bits[1] and ovh_bits[0], in that order. Slot 63 of every row is a termination bit of value 0. Every other slot carries one payload bit, which gives 5540 payload bits per frame.
- R3: in_ready is 1 only in payload slots. A payload bit is taken on a clock edge where in_valid and in_ready are both 1, and payload bits fill the slots in arrival order.
- R4: Slots 2k and 2k+1 form one symbol pair, with the earlier bit as the MSB. sym_valid pulses for one cycle, in the cycle after the edge that fills slot 2k+1.
- R5: The code-to-value mapping is 00→0, 01→1, 11→2, 10→3. This is the same Gray mapping as the levels -1, -1/3, +1/3, +1.
- R6: For a non-termination symbol with input value x, the precoder value is p = (x − p_prev) mod 4. sym_code is the Gray code of p.
- R7: sym_is_term is 1 on the 32nd symbol of every row. Its code is 10 when the last payload bit of the row is 1, and 00 when that bit is 0. The precoder state then becomes 3 or 0 to match.
- R8: sym_frame_start is 1 on the first symbol of each frame and 0 on all other symbols. Frames follow one another without gaps.
- R9: While in_valid is 0 during a payload slot, the frame position holds and no symbol is produced. No bit is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload bit is present |
| in_data | input | 1 | Payload bit |
| in_ready | output | 1 | Block accepts a payload bit this cycle |
| ovh_bits | input | 4 | Overhead bits, held stable, bit 3 sent first |
| sym_valid | output | 1 | Symbol output is valid |
| sym_code | output | 2 | Gray-coded precoded level |
| sym_is_term | output | 1 | Symbol is a row termination symbol |
| sym_frame_start | output | 1 | Symbol is the first of a frame |

## Verification
A symbol is due one cycle after the edge that fills its second slot. That edge may be a payload transfer or a slot the block fills itself. The bench therefore compares outputs at the falling edge after each rising edge, and only when sym_valid is high. An independent model walks the same frame layout and the same payload order, so stalls move the expected symbols in step with the design rather than onto fixed cycle numbers. The driver reads in_ready at the falling edge, where it depends only on registered state, so it knows which rising edge completes each transfer.

// File: rtl/pam4_lane_pkg.sv
package pam4_lane_pkg;

    typedef enum logic [1:0] {
        SLOT_OVH  = 2'd0,
        SLOT_DATA = 2'd1,
        SLOT_TERM = 2'd2
    } slot_kind_e;

    typedef struct packed {
        logic [1:0] pair;
        logic       term;
        logic       fstart;
    } sym_req_t;

    // Gray code to symbol value: 00->0, 01->1, 11->2, 10->3
    function automatic logic [1:0] gray_to_val(input logic [1:0] g);
        return {g[1], g[1] ^ g[0]};
    endfunction

    // Symbol value to Gray code: 0->00, 1->01, 2->11, 3->10
    function automatic logic [1:0] val_to_gray(input logic [1:0] v);
        return {v[1], v[1] ^ v[0]};
    endfunction

endpackage

// File: rtl/lane_slot_ctr.sv
module lane_slot_ctr
    import pam4_lane_pkg::*;
#(
    parameter int ROW_BITS = 64,
    parameter int ROWS     = 88,
    parameter int OVH_BITS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output slot_kind_e                  kind,
    output logic [$clog2(ROW_BITS)-1:0] col,
    output logic [$clog2(ROWS)-1:0]     row,
    output logic                        advance
);
    localparam int CW = $clog2(ROW_BITS);
    localparam int RW = $clog2(ROWS);

    typedef struct packed {
        logic [CW-1:0] col;
        logic [RW-1:0] row;
    } pos_t;

    pos_t st_q, st_d;

    always_comb begin
        if (st_q.row == '0 && int'(st_q.col) < OVH_BITS)
            kind = SLOT_OVH;
        else if (st_q.col == CW'(ROW_BITS - 1))
            kind = SLOT_TERM;
        else
            kind = SLOT_DATA;

        advance = (kind != SLOT_DATA) || in_valid;

        st_d = st_q;
        if (advance) begin
            if (st_q.col == CW'(ROW_BITS - 1)) begin
                st_d.col = '0;
                st_d.row = (st_q.row == RW'(ROWS - 1)) ? '0 : st_q.row + 1'b1;
            end else begin
                st_d.col = st_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col = st_q.col;
    assign row = st_q.row;

    // R9: a payload slot without valid holds the frame position
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SLOT_DATA && !in_valid) |=> $stable(st_q));

    // R2: the last slot of a row is always followed by slot 0
    p_row_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.col == CW'(ROW_BITS - 1)) |=> (st_q.col == '0));

endmodule

// File: rtl/pam4_precoder.sv
module pam4_precoder
    import pam4_lane_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  sym_req_t   req,
    output logic       sym_valid,
    output logic [1:0] sym_code,
    output logic       sym_is_term,
    output logic       sym_frame_start
);
    typedef struct packed {
        logic [1:0] p;
        logic       vld;
        logic [1:0] code;
        logic       term;
        logic       fs;
    } pc_state_t;

    pc_state_t st_q, st_d;
    logic [1:0] x_val;
    logic [1:0] p_new;

    always_comb begin
        x_val = gray_to_val(req.pair);
        if (req.term)
            p_new = req.pair[1] ? 2'd3 : 2'd0;   // outer level picked by last data bit
        else
            p_new = x_val - st_q.p;              // modulo-4 by 2-bit wrap

        st_d      = st_q;
        st_d.vld  = req_valid;
        if (req_valid) begin
            st_d.p    = p_new;
            st_d.code = val_to_gray(p_new);
            st_d.term = req.term;
            st_d.fs   = req.fstart;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sym_valid       = st_q.vld;
    assign sym_code        = st_q.code;
    assign sym_is_term     = st_q.term;
    assign sym_frame_start = st_q.fs;

    // R7: a termination symbol always leaves at an outer level (code 10 or 00)
    p_term_outer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_is_term) |-> (sym_code[0] == 1'b0));

    // R4: two slots per symbol, so valid never lasts two cycles
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid);

endmodule

// File: rtl/pam4_lane_framer.sv
module pam4_lane_framer
    import pam4_lane_pkg::*;
#(
    parameter int ROW_BITS = 64,
    parameter int ROWS     = 88,
    parameter int OVH_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_data,
    output logic                in_ready,
    input  logic [OVH_BITS-1:0] ovh_bits,
    output logic                sym_valid,
    output logic [1:0]          sym_code,
    output logic                sym_is_term,
    output logic                sym_frame_start
);
    localparam int CW = $clog2(ROW_BITS);
    localparam int RW = $clog2(ROWS);
    localparam int OW = (OVH_BITS > 1) ? $clog2(OVH_BITS) : 1;

    slot_kind_e     kind;
    logic [CW-1:0]  col;
    logic [RW-1:0]  row;
    logic           adv;
    logic           slot_bit;
    logic           hold_q, hold_d;
    logic           req_valid;
    sym_req_t       req;
    logic [OVH_BITS-1:0] ovh_rev;

    lane_slot_ctr #(
        .ROW_BITS (ROW_BITS),
        .ROWS     (ROWS),
        .OVH_BITS (OVH_BITS)
    ) i_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .kind     (kind),
        .col      (col),
        .row      (row),
        .advance  (adv)
    );

    assign ovh_rev  = {<<{ovh_bits}};
    assign in_ready = (kind == SLOT_DATA);

    always_comb begin
        unique case (kind)
            SLOT_OVH:  slot_bit = ovh_rev[col[OW-1:0]];
            SLOT_TERM: slot_bit = 1'b0;
            default:   slot_bit = in_data;
        endcase

        hold_d      = (adv && !col[0]) ? slot_bit : hold_q;
        req_valid   = adv && col[0];
        req.pair    = {hold_q, slot_bit};
        req.term    = (kind == SLOT_TERM);
        req.fstart  = (row == '0) && (col == CW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_d;
    end

    pam4_precoder i_pre (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req             (req),
        .sym_valid       (sym_valid),
        .sym_code        (sym_code),
        .sym_is_term     (sym_is_term),
        .sym_frame_start (sym_frame_start)
    );

    // R8: the first symbol of a frame is never a termination symbol
    p_fstart_not_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_frame_start) |-> !sym_is_term);

    // R3: no payload is taken in a slot the block fills itself
    p_ready_only_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row == '0 && col == '0) |-> !in_ready);

endmodule

// File: tb/test_pam4_lane_framer.sv
module test_pam4_lane_framer;
    localparam int  CLK_PERIOD = 10;
    localparam int  ROW_BITS   = 64;
    localparam int  ROWS       = 88;
    localparam logic [3:0] OVH = 4'b1011;
    localparam int  TARGET     = 2816 + 400;
    localparam int  HEAD_N     = 6;
    // first 8 payload bits, bit 7 sent first
    localparam logic [7:0] HEAD_BITS = 8'b1001_1100;
    // expected codes: two overhead symbols then four payload symbols
    localparam logic [1:0] HEAD_EXP [HEAD_N] = '{2'b10, 2'b10, 2'b00, 2'b01, 2'b01, 2'b10};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_data = 1'b0;
    logic in_ready;
    logic sym_valid, sym_is_term, sym_frame_start;
    logic [1:0] sym_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pam4_lane_framer i_pam4_lane_framer (
        .clk             (clk),
        .rst_n           (rst_n),
        .in_valid        (in_valid),
        .in_data         (in_data),
        .in_ready        (in_ready),
        .ovh_bits        (OVH),
        .sym_valid       (sym_valid),
        .sym_code        (sym_code),
        .sym_is_term     (sym_is_term),
        .sym_frame_start (sym_frame_start)
    );

    function automatic logic bitgen(input int idx);
        if (idx < 8) return HEAD_BITS[7 - idx];
        return logic'(((idx * 7) ^ (idx >> 2) ^ (idx / 3)) & 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: in_ready depends on registered state only, so it is read at negedge
    int  didx_drv = 0;
    bit  acc = 0;
    int  cyc = 0;
    initial begin
        wait (rst_n);
        while (!done) begin
            @(negedge clk);
            if (acc) didx_drv++;
            cyc++;
            in_data  = bitgen(didx_drv);
            in_valid = (cyc % 7) != 3;          // periodic gaps exercise R9
            acc      = in_valid && in_ready;
        end
        in_valid = 1'b0;
    end

    // independent model of the frame
    int mcol = 0, mrow = 0, didx_mod = 0, pprev = 0, nsym = 0;
    int last_data = 0;

    function automatic int g2v(input int g);
        case (g) 0: return 0; 1: return 1; 3: return 2; default: return 3; endcase
    endfunction
    function automatic int v2g(input int v);
        case (v) 0: return 0; 1: return 1; 2: return 3; default: return 2; endcase
    endfunction

    task automatic next_bit(output int b, output bit is_term);
        is_term = 0;
        if (mrow == 0 && mcol < 4) b = OVH[3 - mcol];
        else if (mcol == ROW_BITS - 1) begin b = 0; is_term = 1; end
        else begin b = bitgen(didx_mod); didx_mod++; end
        if (mcol == ROW_BITS - 1) begin
            mcol = 0;
            mrow = (mrow == ROWS - 1) ? 0 : mrow + 1;
        end else mcol++;
    endtask

    initial begin
        wait (rst_n);
        while (!done) begin
            @(negedge clk);
            if (sym_valid) begin
                int b0, b1, pair, p, ecode;
                bit t0, t1, fs;
                fs = (mrow == 0 && mcol == 0);
                next_bit(b0, t0);
                next_bit(b1, t1);
                pair = b0 * 2 + b1;
                if (t1) p = b0 ? 3 : 0;                 // R7 forced outer level
                else    p = (g2v(pair) - pprev + 4) % 4; // R5, R6
                pprev = p;
                ecode = v2g(p);
                // R4, R9: every valid symbol matches the next model symbol in order
                chk(sym_code == 2'(ecode), t1 ? "R7" : "R6", sym_code, ecode);
                chk(sym_is_term == t1, "R7", sym_is_term, t1);
                chk(sym_frame_start == fs, "R8", sym_frame_start, fs);
                if (nsym < HEAD_N)                     // R2 overhead order, R5 table
                    chk(sym_code == HEAD_EXP[nsym], "R2", sym_code, HEAD_EXP[nsym]);
                nsym++;
                if (nsym == TARGET) done = 1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", nsym, TARGET);
            done = 1;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sym_valid == 1'b0, "R1", sym_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R1", in_ready, 0);    // R3: overhead slot
        wait (done);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(sym_valid == 1'b0, "R1", sym_valid, 0);
        chk(in_ready == 1'b0, "R1", in_ready, 0);
        chk(nsym >= 2 * ROWS * (ROW_BITS / 2) / 2, "R8", nsym, TARGET);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule